// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 8-bit tri-state buses, called side A and side B. Each pad is split into separate input, output and output-enable signals. Two storage registers hold data. One register latches side A. The other latches side B. Each register has its own capture strobe. The strobes are sampled in the system clock domain, and a register loads on the clock edge at which its strobe is first seen high.

An active-low enable and a direction input set the bus mode. A small state machine with three states drives that mode. In `MODE_ISOLATE` neither side is driven. In `MODE_DRIVE_B` side B is driven from side A. In `MODE_DRIVE_A` side A is driven from side B. For each direction, a select input decides what the driven side carries. It carries either the live value on the opposite bus or the value held in the matching register. A build-time parameter `INVERT` gives a variant that complements every driven data bit.

The state transitions are named as follows:
- `GO_B` (ISOLATE to DRIVE_B): enable is low and direction is high.
- `GO_A` (ISOLATE to DRIVE_A): enable is low and direction is low.
- `HOLD` (a drive state to itself): the request is unchanged.
- `RELEASE` (a drive state to ISOLATE): enable goes high or direction flips.

A change of direction always passes through one ISOLATE cycle. This is break-before-make behaviour, so the two sides are never driven together.

Top module: `regd_bus_xcvr`

## Requirements
- R1: A synchronous active-low reset clears both registers to zero and puts the machine in ISOLATE. While reset is held, both enables and both data outputs are zero.
- R2: The side-A register loads `a_in` at a clock edge where `strb_ab` is 1 and was 0 at the previous edge. At all other edges it keeps its value, including while the strobe stays high.
- R3: The side-B register loads `b_in` at a clock edge where `strb_ba` is 1 and was 0 at the previous edge. At all other edges it keeps its value.
- R4: When `en_n` is 1 at a clock edge, both `a_oe` and `b_oe` are 0 after that edge.
- R5: Captures under R2 and R3 take place in ISOLATE too. A value stored while isolated is the one later presented in stored mode.
- R6: From ISOLATE, `en_n`=0 with `dir`=1 at an edge sets `b_oe`=1 after that edge. It stays 1 while that request holds.
- R7: From ISOLATE, `en_n`=0 with `dir`=0 at an edge sets `a_oe`=1 after that edge. It stays 1 while that request holds.
- R8: `a_oe` and `b_oe` are never 1 together. When the direction flips while enabled, there is exactly one cycle with both at 0 before the other side is driven.
- R9: While `b_oe` is 1, `b_out` equals the live `a_in` when `sel_ab`=0, and the side-A register when `sel_ab`=1. The select acts without a clock delay.
- R10: While `a_oe` is 1, `a_out` equals the live `b_in` when `sel_ba`=0, and the side-B register when `sel_ba`=1.
- R11: An output whose enable is 0 reads all zeros.
- R12: With `INVERT`=1, every driven data value is the bitwise complement of the R9 or R10 value. Enables, registers and undriven outputs behave the same as with `INVERT`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_n | input | 1 | Output enable, active low |
| dir | input | 1 | 1: drive side B, 0: drive side A |
| strb_ab | input | 1 | Capture strobe for the side-A register |
| strb_ba | input | 1 | Capture strobe for the side-B register |
| sel_ab | input | 1 | Side B source: 0 live A, 1 stored A |
| sel_ba | input | 1 | Side A source: 0 live B, 1 stored B |
| a_in | input | W | Side A pad input |
| a_out | output | W | Side A pad output data |
| a_oe | output | 1 | Side A pad output enable |
| b_in | input | W | Side B pad input |
| b_out | output | W | Side B pad output data |
| b_oe | output | 1 | Side B pad output enable |

## Verification
The hardest case to reach is a register captured while the block is isolated. Its value cannot be seen at any port until the matching side is driven later with the stored source selected.

The stimulus targets this case directly. It pulses a strobe with the enable high, then enables the opposite direction with the select set to stored. It then checks that the earlier word appears rather than the current bus value.

A long random phase follows, with biased enable and direction toggling. It flips direction while enabled so that every transition through the break-before-make cycle is compared against the reference model.

// File: rtl/regd_bus_xcvr_pkg.sv
package regd_bus_xcvr_pkg;
    typedef enum logic [1:0] {
        MODE_ISOLATE = 2'd0,
        MODE_DRIVE_B = 2'd1,
        MODE_DRIVE_A = 2'd2
    } mode_e;
endpackage

// File: rtl/bxcvr_capture.sv
module bxcvr_capture #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic strobe_q;
    logic load;

    // a new strobe level seen at this edge
    assign load = strobe & ~strobe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            q        <= '0;
        end else begin
            strobe_q <= strobe;
            if (load) begin
                q <= din;
            end
        end
    end
endmodule

// File: rtl/bxcvr_mode_fsm.sv
module bxcvr_mode_fsm
    import regd_bus_xcvr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_n,
    input  logic dir,
    output logic a_oe,
    output logic b_oe
);
    mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_ISOLATE: begin
                if (!en_n && dir)       state_d = MODE_DRIVE_B;  // GO_B
                else if (!en_n && !dir) state_d = MODE_DRIVE_A;  // GO_A
            end
            MODE_DRIVE_B: begin
                if (en_n || !dir)       state_d = MODE_ISOLATE;  // RELEASE
            end
            MODE_DRIVE_A: begin
                if (en_n || dir)        state_d = MODE_ISOLATE;  // RELEASE
            end
            default:                    state_d = MODE_ISOLATE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= MODE_ISOLATE;
        else        state_q <= state_d;
    end

    always_comb begin
        a_oe = 1'b0;
        b_oe = 1'b0;
        unique case (state_q)
            MODE_ISOLATE: ;
            MODE_DRIVE_B: b_oe = 1'b1;
            MODE_DRIVE_A: a_oe = 1'b1;
            default:      ;
        endcase
    end
endmodule

// File: rtl/bxcvr_outmux.sv
module bxcvr_outmux #(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic         oe,
    input  logic         sel_stored,
    input  logic [W-1:0] live,
    input  logic [W-1:0] stored,
    output logic [W-1:0] dout
);
    logic [W-1:0] raw;
    logic [W-1:0] shaped;

    assign raw = sel_stored ? stored : live;

    generate
        if (INVERT) begin : g_inv
            assign shaped = ~raw;
        end else begin : g_pass
            assign shaped = raw;
        end
    endgenerate

    assign dout = oe ? shaped : '0;
endmodule

// File: rtl/regd_bus_xcvr.sv
module regd_bus_xcvr #(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_n,
    input  logic         dir,
    input  logic         strb_ab,
    input  logic         strb_ba,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_oe
);
    logic [W-1:0] hold_a;
    logic [W-1:0] hold_b;

    bxcvr_capture #(.W(W)) u_cap_a (
        .clk(clk), .rst_n(rst_n), .strobe(strb_ab), .din(a_in), .q(hold_a)
    );

    bxcvr_capture #(.W(W)) u_cap_b (
        .clk(clk), .rst_n(rst_n), .strobe(strb_ba), .din(b_in), .q(hold_b)
    );

    bxcvr_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir(dir),
        .a_oe(a_oe), .b_oe(b_oe)
    );

    bxcvr_outmux #(.W(W), .INVERT(INVERT)) u_mux_b (
        .oe(b_oe), .sel_stored(sel_ab), .live(a_in), .stored(hold_a), .dout(b_out)
    );

    bxcvr_outmux #(.W(W), .INVERT(INVERT)) u_mux_a (
        .oe(a_oe), .sel_stored(sel_ba), .live(b_in), .stored(hold_b), .dout(a_out)
    );
endmodule

// File: rtl/regd_bus_xcvr_chk.sv
module regd_bus_xcvr_chk #(
    parameter int W      = 8,
    parameter bit INVERT = 1'b0
) (
    input logic         clk,
    input logic         rst_n,
    input logic         en_n,
    input logic         dir,
    input logic         sel_ab,
    input logic         sel_ba,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic [W-1:0] a_out,
    input logic [W-1:0] b_out,
    input logic         a_oe,
    input logic         b_oe
);
    localparam logic [W-1:0] FLIP = {W{INVERT}};

    // R8
    oe_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({a_oe, b_oe}));

    // R8
    a_turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(a_oe) |-> !$past(b_oe));

    // R4
    isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_n |=> (!a_oe && !b_oe));

    // R6
    drive_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && dir && !a_oe) |=> b_oe);

    // R7
    drive_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_n && !dir && !b_oe) |=> a_oe);

    // R9
    b_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_oe && !sel_ab) |-> (b_out == (a_in ^ FLIP)));

    // R10
    a_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_oe && !sel_ba) |-> (a_out == (b_in ^ FLIP)));

    // R11
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((!a_oe -> a_out == '0) && (!b_oe -> b_out == '0)));
endmodule

bind regd_bus_xcvr regd_bus_xcvr_chk #(.W(W), .INVERT(INVERT)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
    .a_out(a_out), .b_out(b_out), .a_oe(a_oe), .b_oe(b_oe)
);

// File: tb/regd_bus_xcvr_bench.sv
`timescale 1ns/1ps
module regd_bus_xcvr_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_n = 1'b1, dir = 1'b0;
    logic       strb_ab = 1'b0, strb_ba = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [7:0] a_in = '0, b_in = '0;
    logic [7:0] a_out, b_out, ai_out, bi_out;
    logic       a_oe, b_oe, ai_oe, bi_oe;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    // reference model state: 0 isolate, 1 drive B, 2 drive A
    int         m_mode = 0;
    logic [7:0] m_ra = '0, m_rb = '0;
    logic       m_pa = 1'b0, m_pb = 1'b0;

    always #2.5 clk = ~clk;

    regd_bus_xcvr u_regd_bus_xcvr (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir(dir),
        .strb_ab(strb_ab), .strb_ba(strb_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
    );

    regd_bus_xcvr #(.W(8), .INVERT(1'b1)) u_regd_bus_xcvr_inv (
        .clk(clk), .rst_n(rst_n), .en_n(en_n), .dir(dir),
        .strb_ab(strb_ab), .strb_ba(strb_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
        .a_in(a_in), .a_out(ai_out), .a_oe(ai_oe),
        .b_in(b_in), .b_out(bi_out), .b_oe(bi_oe)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m_mode = 0; m_ra = '0; m_rb = '0; m_pa = 1'b0; m_pb = 1'b0;
        end else begin
            if (strb_ab && !m_pa) m_ra = a_in;
            if (strb_ba && !m_pb) m_rb = b_in;
            m_pa = strb_ab;
            m_pb = strb_ba;
            case (m_mode)
                0: if (!en_n) m_mode = dir ? 1 : 2;
                1: if (en_n || !dir) m_mode = 0;
                default: if (en_n || dir) m_mode = 0;
            endcase
        end
    endtask

    task automatic compare();
        logic       eb_oe, ea_oe;
        logic [7:0] eb, ea, ebi, eai;
        eb_oe = (m_mode == 1);
        ea_oe = (m_mode == 2);
        eb  = eb_oe ? (sel_ab ? m_ra : a_in) : 8'h00;
        ea  = ea_oe ? (sel_ba ? m_rb : b_in) : 8'h00;
        ebi = eb_oe ? ~(sel_ab ? m_ra : a_in) : 8'h00;
        eai = ea_oe ? ~(sel_ba ? m_rb : b_in) : 8'h00;
        if (!rst_n) begin
            chk(a_oe == 0 && b_oe == 0, "R1 enables", {6'b0, a_oe, b_oe}, 8'h00);
            chk(a_out == 0 && b_out == 0, "R1 data", a_out | b_out, 8'h00);
        end else begin
            chk(b_oe == eb_oe, "R6 b_oe", {7'b0, b_oe}, {7'b0, eb_oe});
            chk(a_oe == ea_oe, "R7 a_oe", {7'b0, a_oe}, {7'b0, ea_oe});
            chk(b_out == eb, "R9 b_out", b_out, eb);
            chk(a_out == ea, "R10 a_out", a_out, ea);
            chk(bi_out == ebi && bi_oe == eb_oe, "R12 b side", bi_out, ebi);
            chk(ai_out == eai && ai_oe == ea_oe, "R12 a side", ai_out, eai);
            chk(!(a_oe && b_oe), "R8 exclusive", {6'b0, a_oe, b_oe}, 8'h00);
        end
    endtask

    // one clock: model advances at the edge, outputs compared 1 ns later
    task automatic tick();
        @(posedge clk);
        model_edge();
        #1;
        compare();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: reset with busy inputs
        a_in = 8'hA5; b_in = 8'h3C; strb_ab = 1'b1; strb_ba = 1'b1; en_n = 1'b0; dir = 1'b1;
        repeat (3) tick();
        rst_n = 1'b1; strb_ab = 1'b0; strb_ba = 1'b0; en_n = 1'b1;
        tick();

        // R2: capture on rising strobe only
        en_n = 1'b0; dir = 1'b1; sel_ab = 1'b1; a_in = 8'h5A;
        tick();
        strb_ab = 1'b1;
        tick();
        a_in = 8'h11;
        tick();
        chk(b_out == 8'h5A, "R2 held strobe no reload", b_out, 8'h5A);
        strb_ab = 1'b0; sel_ab = 1'b0;
        tick();
        chk(b_out == 8'h11, "R9 live path", b_out, 8'h11);

        // R8: direction flip while enabled
        dir = 1'b0;
        tick();
        chk(!a_oe && !b_oe, "R8 turnaround gap", {6'b0, a_oe, b_oe}, 8'h00);
        tick();
        chk(a_oe && !b_oe, "R7 side A driven", {6'b0, a_oe, b_oe}, 8'h02);

        // R3: side-B capture
        sel_ba = 1'b1; b_in = 8'hE7; strb_ba = 1'b1;
        tick();
        b_in = 8'h08;
        tick();
        chk(a_out == 8'hE7, "R3 stored B", a_out, 8'hE7);
        chk(ai_out == 8'h18, "R12 inverted stored B", ai_out, 8'h18);
        strb_ba = 1'b0;

        // R4 / R5 / R11: capture while isolated
        en_n = 1'b1;
        tick();
        chk(!a_oe && !b_oe, "R4 isolated", {6'b0, a_oe, b_oe}, 8'h00);
        chk(a_out == 0 && b_out == 0, "R11 quiet outputs", a_out | b_out, 8'h00);
        a_in = 8'hC3; strb_ab = 1'b1;
        tick();
        strb_ab = 1'b0; a_in = 8'h99;
        tick();
        chk(b_out == 8'h00, "R11 b undriven", b_out, 8'h00);
        en_n = 1'b0; dir = 1'b1; sel_ab = 1'b1;
        tick();
        chk(b_oe && b_out == 8'hC3, "R5 isolated capture", b_out, 8'hC3);

        // random phase
        for (int i = 0; i < 3000; i++) begin
            logic [7:0] r;
            r = 8'($urandom);
            a_in = 8'($urandom);
            b_in = 8'($urandom);
            strb_ab = r[0];
            strb_ba = r[1];
            sel_ab  = r[2];
            sel_ba  = r[3];
            if (r[6:4] == 3'd0) en_n = ~en_n;
            if (r[7] && r[5]) dir = ~dir;
            if (i == 1500) rst_n = 1'b0;
            if (i == 1503) rst_n = 1'b1;
            tick();
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule